// File: doc/BRIEF.md
# Low-Power Mode and Signature Controller

This block decides when a serial memory slave sleeps and when it wakes. An SPI front end clocks the serial bus and passes four things to the block in the system clock domain: a pulse for each complete opcode byte, a pulse when chip select is released, a busy flag for an erase, program or status write in progress, and the number of bits clocked into the current frame. From these the block runs a four-state mode machine (Standby, Entering, Down and Releasing). It tells the front end when commands must be blocked, raises a low-power request, and supplies the bit to shift out during a signature read.

The sleep opcode takes effect only when chip select is released right after its eighth bit. The low-power request then rises after a parameterised entry delay. While the block is asleep, only the signature opcode is honoured. The signature byte starts after 24 dummy address bits and repeats for as long as the host keeps clocking. Releasing chip select after a signature opcode in the asleep state starts a parameterised release delay, and the block is ready again once that delay ends. No current reduction is modelled here. The delays are counted in system clocks.

Top module: `dpd_sig_ctrl`

## Requirements
- R1: After reset the block is in Standby: `ready`=1, `cmd_block`=0, `lp_req`=0, `sig_oe`=0.
- R2: Opcode 0xB9, accepted in Standby with `busy`=0 and followed by a `cs_rise` pulse while `bit_pos`=8, makes `ready`=0 and `cmd_block`=1 from the next cycle. `lp_req` becomes 1 exactly ENTER_CYC cycles after that.
- R3: If `bit_pos` moves away from 8 after opcode 0xB9 and before `cs_rise`, the sleep request is dropped and the block stays in Standby.
- R4: Opcode 0xB9 received while `busy`=1 is ignored.
- R5: While `lp_req`=1, every opcode other than 0xAB is ignored: `lp_req` stays 1 and `sig_oe` stays 0.
- R6: After opcode 0xAB is accepted, `sig_oe` is 0 while `bit_pos` < 32. From `bit_pos`=32 onwards `sig_oe`=1 and `sig_bit` = SIG[7 - (`bit_pos` mod 8)], so the signature goes out MSB first.
- R7: The signature byte repeats without limit while bits keep arriving, also after `bit_pos` wraps modulo 2^CNT_W.
- R8: A `cs_rise` after opcode 0xAB was accepted in the asleep state clears `lp_req` in the next cycle, including when no signature bit was clocked. `ready` returns to 1 exactly REL_CYC cycles after that, and `cmd_block` stays 1 until then.
- R9: During the release delay every opcode is ignored, including 0xB9 with a correct `cs_rise`.
- R10: Opcode 0xAB in Standby serves the signature without changing mode when `busy`=0. When `busy`=1 it is ignored and `sig_oe` stays 0.
- R11: `cs_rise` ends the signature output: `sig_oe` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | One-cycle pulse when a full opcode byte has arrived |
| op_code | input | 8 | Opcode byte, valid with `op_valid` |
| cs_rise | input | 1 | One-cycle pulse when chip select is released |
| busy | input | 1 | Erase, program or status write in progress |
| bit_pos | input | CNT_W | Bits clocked into the current frame, wrapping modulo 2^CNT_W (CNT_W >= 6) |
| cmd_block | output | 1 | Front end must ignore commands except the signature opcode |
| ready | output | 1 | Block is in Standby |
| lp_req | output | 1 | Low-power state is active |
| sig_oe | output | 1 | Signature bit is being driven |
| sig_bit | output | 1 | Current signature bit |

## Verification
The hardest situation to reach is an opcode or chip-select release arriving inside a timed window, either the release delay or the stretch just before the entry delay expires, because each window lasts only a few cycles after a full frame. The bench keeps both delays short and starts a complete sleep frame immediately after the wake release. The whole frame then lands inside the release window. The signature repeat after the bit counter wraps is reached by stepping `bit_pos` past 2^CNT_W in one long frame.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [1:0] {
    PM_STBY  = 2'd0,
    PM_ENTER = 2'd1,
    PM_DOWN  = 2'd2,
    PM_WAKE  = 2'd3
  } pm_state_e;

  localparam logic [7:0] OPC_SLEEP = 8'hB9;
  localparam logic [7:0] OPC_SIGRD = 8'hAB;
  localparam int         OP_BITS   = 8;
  localparam int         SIG_START = 32;
endpackage

// File: rtl/dpd_cmd_filter.sv
module dpd_cmd_filter
  import dpd_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [7:0]       op_code,
  input  logic             cs_rise,
  input  logic             busy,
  input  logic [CNT_W-1:0] bit_pos,
  input  pm_state_e        state,
  output logic             sleep_go,
  output logic             wake_go,
  output logic             sig_frame
);
  localparam logic [CNT_W-1:0] POS_OP = CNT_W'(OP_BITS);

  logic sleep_arm_q, sleep_arm_d;
  logic sig_frame_q, sig_frame_d;
  logic from_low_q, from_low_d;
  logic sig_ok, sleep_ok;

  always_comb begin
    sleep_ok = (op_code == OPC_SLEEP) && (state == PM_STBY) && !busy;
    sig_ok   = (op_code == OPC_SIGRD) &&
               ((state == PM_ENTER) || (state == PM_DOWN) ||
                ((state == PM_STBY) && !busy));
  end

  always_comb begin
    sleep_arm_d = sleep_arm_q;
    sig_frame_d = sig_frame_q;
    from_low_d  = from_low_q;
    if (cs_rise) begin
      sleep_arm_d = 1'b0;
      sig_frame_d = 1'b0;
      from_low_d  = 1'b0;
    end else if (op_valid) begin
      if (sleep_ok) sleep_arm_d = 1'b1;
      if (sig_ok) begin
        sig_frame_d = 1'b1;
        from_low_d  = (state != PM_STBY);
      end
    end else if (sleep_arm_q && (bit_pos != POS_OP)) begin
      sleep_arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_arm_q <= 1'b0;
      sig_frame_q <= 1'b0;
      from_low_q  <= 1'b0;
    end else begin
      sleep_arm_q <= sleep_arm_d;
      sig_frame_q <= sig_frame_d;
      from_low_q  <= from_low_d;
    end
  end

  assign sleep_go  = cs_rise && sleep_arm_q && (bit_pos == POS_OP);
  assign wake_go   = cs_rise && sig_frame_q && from_low_q;
  assign sig_frame = sig_frame_q;

  // R5
  ignore_in_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_DOWN && op_valid && !cs_rise && op_code != OPC_SIGRD && !sig_frame_q)
      |=> !sig_frame_q && !sleep_arm_q);

  // R11
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sig_frame_q && !sleep_arm_q);
endmodule

// File: rtl/dpd_mode_fsm.sv
module dpd_mode_fsm
  import dpd_pkg::*;
#(
  parameter int ENTER_CYC = 4,
  parameter int REL_CYC   = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_go,
  input  logic      wake_go,
  output pm_state_e state,
  output logic      ready,
  output logic      cmd_block,
  output logic      lp_req
);
  localparam int MAX_CYC = (ENTER_CYC > REL_CYC) ? ENTER_CYC : REL_CYC;
  localparam int DLY_W   = $clog2(MAX_CYC + 1);
  localparam logic [DLY_W-1:0] ENTER_LD = DLY_W'(ENTER_CYC - 1);
  localparam logic [DLY_W-1:0] REL_LD   = DLY_W'(REL_CYC - 1);

  pm_state_e        state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      PM_STBY: begin
        if (sleep_go) begin
          state_d = PM_ENTER;
          cnt_d   = ENTER_LD;
          cnt_en  = 1'b1;
        end
      end
      PM_ENTER: begin
        cnt_en = 1'b1;
        if (wake_go) begin
          state_d = PM_WAKE;
          cnt_d   = REL_LD;
        end else if (cnt_q == '0) begin
          state_d = PM_DOWN;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PM_DOWN: begin
        if (wake_go) begin
          state_d = PM_WAKE;
          cnt_d   = REL_LD;
          cnt_en  = 1'b1;
        end
      end
      PM_WAKE: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) state_d = PM_STBY;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = PM_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_STBY;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state     = state_q;
  assign ready     = (state_q == PM_STBY);
  assign cmd_block = (state_q != PM_STBY);
  assign lp_req    = (state_q == PM_DOWN);

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_go && state_q == PM_STBY) |=> state_q == PM_ENTER);

  // R8
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_go && (state_q == PM_DOWN || state_q == PM_ENTER)) |=> state_q == PM_WAKE);

  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_WAKE) |=> (state_q == PM_WAKE || state_q == PM_STBY));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < DLY_W'(MAX_CYC));
endmodule

// File: rtl/dpd_sig_shift.sv
module dpd_sig_shift
  import dpd_pkg::*;
#(
  parameter int         CNT_W = 6,
  parameter logic [7:0] SIG   = 8'h29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_frame,
  input  logic             cs_rise,
  input  logic [CNT_W-1:0] bit_pos,
  output logic             sig_oe,
  output logic             sig_bit
);
  localparam logic [CNT_W-1:0] POS_SIG = CNT_W'(SIG_START);

  logic       seen_q, seen_d;
  logic       at_start;
  logic [2:0] sel;

  always_comb begin
    at_start = (bit_pos == POS_SIG);
    seen_d   = seen_q;
    if (cs_rise)                    seen_d = 1'b0;
    else if (sig_frame && at_start) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  always_comb begin
    sel     = ~bit_pos[2:0];
    sig_oe  = sig_frame && (seen_q || at_start);
    sig_bit = sig_oe ? SIG[sel] : 1'b0;
  end

  // R7
  sig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && sig_frame && !cs_rise) |=> seen_q);

  // R11
  sig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !seen_q);
endmodule

// File: rtl/dpd_sig_ctrl.sv
module dpd_sig_ctrl
  import dpd_pkg::*;
#(
  parameter int         CNT_W     = 6,
  parameter int         ENTER_CYC = 4,
  parameter int         REL_CYC   = 6,
  parameter logic [7:0] SIG       = 8'h29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [7:0]       op_code,
  input  logic             cs_rise,
  input  logic             busy,
  input  logic [CNT_W-1:0] bit_pos,
  output logic             cmd_block,
  output logic             ready,
  output logic             lp_req,
  output logic             sig_oe,
  output logic             sig_bit
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  pm_state_e  state;
  logic       sleep_go, wake_go, sig_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dpd_cmd_filter #(.CNT_W(CNT_W)) u_filter (
    .clk(clk), .rst_n(rst_core_n), .op_valid(op_valid), .op_code(op_code),
    .cs_rise(cs_rise), .busy(busy), .bit_pos(bit_pos), .state(state),
    .sleep_go(sleep_go), .wake_go(wake_go), .sig_frame(sig_frame)
  );

  dpd_mode_fsm #(.ENTER_CYC(ENTER_CYC), .REL_CYC(REL_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .sleep_go(sleep_go), .wake_go(wake_go),
    .state(state), .ready(ready), .cmd_block(cmd_block), .lp_req(lp_req)
  );

  dpd_sig_shift #(.CNT_W(CNT_W), .SIG(SIG)) u_sig (
    .clk(clk), .rst_n(rst_core_n), .sig_frame(sig_frame), .cs_rise(cs_rise),
    .bit_pos(bit_pos), .sig_oe(sig_oe), .sig_bit(sig_bit)
  );
endmodule

// File: tb/tb_dpd_sig_ctrl.sv
`timescale 1ns/1ps
module tb_dpd_sig_ctrl;
  localparam int         CNT_W = 6;
  localparam int         E     = 4;
  localparam int         R     = 6;
  localparam logic [7:0] SIGV  = 8'h29;

  logic clk = 1'b0;
  logic rst_n, op_valid, cs_rise, busy;
  logic [7:0] op_code;
  logic [CNT_W-1:0] bit_pos;
  logic cmd_block, ready, lp_req, sig_oe, sig_bit;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpd_sig_ctrl #(.CNT_W(CNT_W), .ENTER_CYC(E), .REL_CYC(R), .SIG(SIGV)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cs_rise(cs_rise), .busy(busy), .bit_pos(bit_pos), .cmd_block(cmd_block),
    .ready(ready), .lp_req(lp_req), .sig_oe(sig_oe), .sig_bit(sig_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_op(input logic [7:0] op);
    @(negedge clk);
    bit_pos = CNT_W'(8); op_code = op; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic cs_end();
    @(negedge clk);
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0; bit_pos = '0;
  endtask

  task automatic go_down();
    send_op(8'hB9); cs_end(); wait_n(E);
  endtask

  task automatic t_reset();
    chk(ready == 1 && cmd_block == 0 && lp_req == 0 && sig_oe == 0, "R1",
        {ready, cmd_block, lp_req, sig_oe}, 4'b1000);
  endtask

  task automatic t_sleep_enter();
    send_op(8'hB9); cs_end();
    chk(ready == 0 && cmd_block == 1, "R2 block", {ready, cmd_block}, 2'b01);
    wait_n(E - 1);
    chk(lp_req == 0, "R2 early", lp_req, 0);
    wait_n(1);
    chk(lp_req == 1, "R2 down", lp_req, 1);
  endtask

  task automatic t_ignore_down();
    send_op(8'h03);
    for (int k = 9; k < 45; k++) begin
      @(negedge clk); bit_pos = CNT_W'(k); #0.5;
      if (k == 40) chk(sig_oe == 0, "R5 read", sig_oe, 0);
    end
    cs_end();
    send_op(8'h06); cs_end();
    send_op(8'hB9); cs_end();
    wait_n(E + 2);
    chk(lp_req == 1 && sig_oe == 0, "R5 stay", {lp_req, sig_oe}, 2'b10);
  endtask

  task automatic sweep_sig(input int last, input string req);
    for (int k = 9; k <= last; k++) begin
      @(negedge clk); bit_pos = CNT_W'(k); #0.5;
      if (k < 32) begin
        if (k == 31) chk(sig_oe == 0, req, sig_oe, 0);
      end else begin
        chk(sig_oe == 1 && sig_bit == SIGV[7 - (k % 8)], (k >= 40) ? "R7" : req,
            {sig_oe, sig_bit}, {1'b1, SIGV[7 - (k % 8)]});
      end
    end
  endtask

  task automatic t_wake_with_sig();
    send_op(8'hAB); sweep_sig(75, "R6");
    cs_end();
    chk(sig_oe == 0, "R11", sig_oe, 0);
    chk(lp_req == 0 && ready == 0 && cmd_block == 1, "R8 rel",
        {lp_req, ready, cmd_block}, 3'b001);
    wait_n(R - 1);
    chk(ready == 0, "R8 early", ready, 0);
    wait_n(1);
    chk(ready == 1 && cmd_block == 0, "R8 ready", {ready, cmd_block}, 2'b10);
  endtask

  task automatic t_wake_no_sig_ignore();
    go_down();
    send_op(8'hAB); cs_end();
    chk(lp_req == 0 && ready == 0, "R8 nosig", {lp_req, ready}, 2'b00);
    send_op(8'hB9); cs_end();
    wait_n(R - 3);
    chk(ready == 1, "R9 done", ready, 1);
    wait_n(E + 2);
    chk(lp_req == 0 && ready == 1, "R9 ignored", {lp_req, ready}, 2'b01);
  endtask

  task automatic t_sleep_cancel();
    send_op(8'hB9);
    @(negedge clk); bit_pos = CNT_W'(9);
    @(negedge clk); bit_pos = CNT_W'(8);
    cs_end(); wait_n(E + 2);
    chk(ready == 1 && lp_req == 0, "R3", {ready, lp_req}, 2'b10);
  endtask

  task automatic t_sleep_busy();
    busy = 1'b1; send_op(8'hB9); cs_end(); busy = 1'b0;
    wait_n(E + 2);
    chk(ready == 1 && lp_req == 0, "R4", {ready, lp_req}, 2'b10);
  endtask

  task automatic t_sig_standby();
    send_op(8'hAB); sweep_sig(48, "R10");
    chk(ready == 1 && cmd_block == 0, "R10 mode", {ready, cmd_block}, 2'b10);
    cs_end();
    chk(ready == 1 && sig_oe == 0, "R10 end", {ready, sig_oe}, 2'b10);
    busy = 1'b1; send_op(8'hAB);
    for (int k = 9; k <= 40; k++) begin @(negedge clk); bit_pos = CNT_W'(k); end
    #0.5;
    chk(sig_oe == 0, "R10 busy", sig_oe, 0);
    cs_end(); busy = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; cs_rise = 1'b0; busy = 1'b0;
    op_code = '0; bit_pos = '0;
    wait_n(3); rst_n = 1'b1; wait_n(4);
    t_reset();
    t_sleep_enter();
    t_ignore_down();
    t_wake_with_sig();
    t_wake_no_sig_ignore();
    t_sleep_cancel();
    t_sleep_busy();
    t_sig_standby();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule